// File: doc/BRIEF.md
# Reversible Branch Condition Code Unit

This block keeps the four-bit condition code that steers conditional branches. Each bit answers one branch type directly: the most significant bit says whether a "positive non-zero" branch goes, then "non-zero", then "negative", and the least significant bit "no overflow". The sequencer writes the code from the sign, zero and overflow flags of an ALU result. To evaluate a branch, it names the branch type on a two-bit selector and strobes an evaluate input, and it reads the taken decision in the same cycle.

A reverse command replaces the code with a second encoding in which every branch type tests the opposite condition: negative-or-zero, zero, positive-or-zero and overflow. The reversed code stays in force until a branch evaluation or an explicit cancel uses it up, and ALU updates are dropped during that time. A hidden state flag tells the two encodings apart, because the normal zero code and the reversed overflow code share the same four bits. The code and the flag can be copied into a save register and loaded back from it. The sequencer does this on interrupt entry and on resume.

Top module: `cc_unit`

## Requirements
- R1: After reset the code reads 0000 (normal overflow), the reversed flag is clear, and no branch type is taken.
- R2: An update stores a normal code chosen by priority: overflow gives 0000, otherwise zero gives 0001, otherwise negative gives 0111, otherwise 1101 (positive).
- R3: br_taken equals code bit 3, 2, 1 or 0 for a selector value of 0 (positive non-zero), 1 (non-zero), 2 (negative) or 3 (no overflow). It is combinational and is 0 whenever br_eval is low.
- R4: A reverse command on a normal code loads the reversed encoding on the next edge: 0001 becomes 1110, 1101 becomes 0010, 0111 becomes 1000 and 0000 becomes 0001.
- R5: While the code is reversed, updates have no effect on the code.
- R6: A branch evaluated against a reversed code decides from the reversed bits. On the next edge the code returns to the matching normal code and updates work again.
- R7: A cancel while reversed returns the matching normal code without a branch.
- R8: A reverse command while already reversed has no effect.
- R9: save copies the code and its reversed flag into the save register. restore loads both back and takes priority over every other command in the same cycle.
- R10: When reverse and update arrive together on a normal code, the reverse applies to the old code and the update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Write the code from the result flags |
| res_neg | input | 1 | Result is negative |
| res_zero | input | 1 | Result is zero |
| res_ovf | input | 1 | Result overflowed |
| rev_cmd | input | 1 | Switch to the reversed encoding |
| rev_cancel | input | 1 | Drop the reversed state |
| save | input | 1 | Copy code and flag to the save register |
| restore | input | 1 | Load code and flag from the save register |
| br_eval | input | 1 | Evaluate a branch this cycle |
| br_sel | input | 2 | Branch type: 0 PNZ, 1 NZ, 2 NEG, 3 NOV |
| br_taken | output | 1 | Branch decision |
| cc_code | output | 4 | Current condition code |

## Verification
A wrong reversed flag does not show in cc_code right away. It shows one cycle later, in a branch that fails to restore the normal code, or in an update that is dropped or wrongly accepted. The bench therefore follows each change of state with a branch or an update and reads the code on the edge after it. A corrupted save register shows only after a restore. The bench restores both a normal and a reversed state, and then checks that the next branch converts the code back (or leaves it as it is).

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_W  = 4;
  localparam int SEL_W = $clog2(CC_W);
  typedef logic [CC_W-1:0] cc_t;

  localparam cc_t N_ZERO = 4'b0001;
  localparam cc_t N_POS  = 4'b1101;
  localparam cc_t N_NEG  = 4'b0111;
  localparam cc_t N_OVF  = 4'b0000;
  localparam cc_t R_OVF  = 4'b0001;

  // state kept by the unit and by its save register
  typedef struct packed {
    logic rev;
    cc_t  code;
  } cc_state_t;
endpackage

// File: rtl/cc_encode.sv
module cc_encode
  import cc_pkg::*;
(
  input  logic neg,
  input  logic zero,
  input  logic ovf,
  output cc_t  code
);
  always_comb begin
    if (ovf)       code = N_OVF;
    else if (zero) code = N_ZERO;
    else if (neg)  code = N_NEG;
    else           code = N_POS;
  end
endmodule

// File: rtl/cc_flip.sv
module cc_flip
  import cc_pkg::*;
#(
  parameter bit TO_REV = 1'b1
) (
  input  cc_t din,
  output cc_t dout
);
  generate
    if (TO_REV) begin : g_fwd
      // every normal code inverts, except overflow which needs a distinct pattern
      assign dout = (din == N_OVF) ? R_OVF : ~din;
    end else begin : g_back
      assign dout = (din == R_OVF) ? N_OVF : ~din;
    end
  endgenerate
endmodule

// File: rtl/cc_branch_mux.sv
module cc_branch_mux
  import cc_pkg::*;
(
  input  cc_t              code,
  input  logic [SEL_W-1:0] sel,
  input  logic             eval,
  output logic             taken
);
  logic [SEL_W-1:0] idx;
  assign idx   = SEL_W'(CC_W - 1) - sel;
  assign taken = eval & code[idx];
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_en,
  input  logic       res_neg,
  input  logic       res_zero,
  input  logic       res_ovf,
  input  logic       rev_cmd,
  input  logic       rev_cancel,
  input  logic       save,
  input  logic       restore,
  input  logic       br_eval,
  input  logic [1:0] br_sel,
  output logic       br_taken,
  output logic [3:0] cc_code
);
  cc_state_t st_q, st_d;
  cc_state_t sv_q;
  logic      sv_en;
  cc_t       enc_code, rev_code, norm_code;

  cc_encode u_enc (
    .neg  (res_neg),
    .zero (res_zero),
    .ovf  (res_ovf),
    .code (enc_code)
  );

  cc_flip #(.TO_REV(1'b1)) u_fwd (
    .din  (st_q.code),
    .dout (rev_code)
  );

  cc_flip #(.TO_REV(1'b0)) u_back (
    .din  (st_q.code),
    .dout (norm_code)
  );

  cc_branch_mux u_mux (
    .code  (st_q.code),
    .sel   (br_sel),
    .eval  (br_eval),
    .taken (br_taken)
  );

  // next state: restore, then leaving reversal, then entering it, then update
  always_comb begin
    st_d = st_q;
    if (restore) begin
      st_d = sv_q;
    end else if (st_q.rev) begin
      if (br_eval || rev_cancel) begin
        st_d.rev  = 1'b0;
        st_d.code = norm_code;
      end
    end else if (rev_cmd) begin
      st_d.rev  = 1'b1;
      st_d.code = rev_code;
    end else if (upd_en) begin
      st_d.code = enc_code;
    end
  end

  assign sv_en = save;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= '0;
    end else if (sv_en) begin
      sv_q <= st_q;
    end
  end

  assign cc_code = st_q.code;
endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic       rev_cmd,
  input logic       rev_cancel,
  input logic       restore,
  input logic       br_eval,
  input logic       br_taken,
  input logic [3:0] cc_code,
  input logic       rev_q,
  input logic [4:0] sv_q
);
  a_r3_taken_needs_eval: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_eval);

  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rev_q |-> (cc_code == 4'b1110 || cc_code == 4'b0010 ||
               cc_code == 4'b1000 || cc_code == 4'b0001));

  a_r2_legal_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_q |-> (cc_code == 4'b0001 || cc_code == 4'b1101 ||
                cc_code == 4'b0111 || cc_code == 4'b0000));

  a_r5_update_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q && upd_en && !restore && !br_eval && !rev_cancel) |=> (rev_q && $stable(cc_code)));

  a_r8_reverse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q && rev_cmd && !restore && !br_eval && !rev_cancel) |=> (rev_q && $stable(cc_code)));

  a_r6_branch_unreverses: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q && br_eval && !restore) |=> !rev_q);

  a_r9_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ({rev_q, cc_code} == $past(sv_q)));
endmodule

bind cc_unit cc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en     (upd_en),
  .rev_cmd    (rev_cmd),
  .rev_cancel (rev_cancel),
  .restore    (restore),
  .br_eval    (br_eval),
  .br_taken   (br_taken),
  .cc_code    (cc_code),
  .rev_q      (st_q.rev),
  .sv_q       (sv_q)
);

// File: tb/sim_cc_unit.sv
module sim_cc_unit;
  localparam int CLK_P = 10;

  logic clk, rst_n;
  logic upd_en, res_neg, res_zero, res_ovf;
  logic rev_cmd, rev_cancel, save, restore, br_eval;
  logic [1:0] br_sel;
  logic br_taken;
  logic [3:0] cc_code;
  int n_chk, n_err;
  bit done;

  cc_unit u0 (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic clr();
    upd_en = 0; res_neg = 0; res_zero = 0; res_ovf = 0;
    rev_cmd = 0; rev_cancel = 0; save = 0; restore = 0;
    br_eval = 0; br_sel = 0;
  endtask

  // apply the inputs already set, take one edge, clear them
  task automatic step();
    @(posedge clk); #2;
    clr();
    #1;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic upd(logic n, logic z, logic o);
    upd_en = 1; res_neg = n; res_zero = z; res_ovf = o;
    step();
  endtask

  task automatic taken_of(logic [1:0] s, output logic t);
    br_eval = 1; br_sel = s; #1; t = br_taken;
    br_eval = 0; #1;
  endtask

  task automatic t_reset();
    logic t;
    chk("R1 code", cc_code, 4'b0000);
    for (int s = 0; s < 4; s++) begin
      taken_of(2'(s), t);
      chk("R1 taken", {3'b0, t}, 4'b0000);
    end
    rev_cmd = 1; step();
    chk("R1 flag clear so reverse works", cc_code, 4'b0001);
    rev_cancel = 1; step();
    chk("R1 back", cc_code, 4'b0000);
  endtask

  task automatic t_update();
    logic t;
    upd(0, 1, 0); chk("R2 zero", cc_code, 4'b0001);
    upd(0, 0, 0); chk("R2 pos", cc_code, 4'b1101);
    upd(1, 0, 0); chk("R2 neg", cc_code, 4'b0111);
    upd(0, 0, 1); chk("R2 ovf", cc_code, 4'b0000);
    upd(1, 1, 1); chk("R2 ovf priority", cc_code, 4'b0000);
    upd(1, 1, 0); chk("R2 zero priority", cc_code, 4'b0001);
    upd(0, 0, 0);
    taken_of(0, t); chk("R3 sel0", {3'b0, t}, 4'b0001);
    taken_of(1, t); chk("R3 sel1", {3'b0, t}, 4'b0001);
    taken_of(2, t); chk("R3 sel2", {3'b0, t}, 4'b0000);
    taken_of(3, t); chk("R3 sel3", {3'b0, t}, 4'b0001);
    br_sel = 0; #1;
    chk("R3 no eval", {3'b0, br_taken}, 4'b0000);
    upd(1, 0, 0);
    taken_of(2, t); chk("R3 neg sel2", {3'b0, t}, 4'b0001);
    taken_of(0, t); chk("R3 neg sel0", {3'b0, t}, 4'b0000);
  endtask

  task automatic rev_of(logic n, logic z, logic o, logic [3:0] nexp, logic [3:0] rexp);
    upd(n, z, o);
    rev_cmd = 1; step();
    chk("R4 reverse", cc_code, rexp);
    rev_cancel = 1; step();
    chk("R7 cancel", cc_code, nexp);
  endtask

  task automatic t_reverse();
    rev_of(0, 1, 0, 4'b0001, 4'b1110);
    rev_of(0, 0, 0, 4'b1101, 4'b0010);
    rev_of(1, 0, 0, 4'b0111, 4'b1000);
    rev_of(0, 0, 1, 4'b0000, 4'b0001);
  endtask

  task automatic t_lock();
    upd(0, 1, 0);
    rev_cmd = 1; step();
    upd(0, 0, 1); chk("R5 update locked", cc_code, 4'b1110);
    upd(1, 0, 0); chk("R5 update locked 2", cc_code, 4'b1110);
    rev_cmd = 1; step(); chk("R8 reverse ignored", cc_code, 4'b1110);
    rev_cancel = 1; step();
  endtask

  task automatic t_branch_rev();
    logic t;
    upd(0, 1, 0);
    rev_cmd = 1; step();
    br_eval = 1; br_sel = 1; #1; t = br_taken;
    chk("R6 zero test taken", {3'b0, t}, 4'b0001);
    step();
    chk("R6 normal again", cc_code, 4'b0001);
    upd(1, 0, 0); chk("R6 unlocked", cc_code, 4'b0111);
    upd(0, 0, 1);
    rev_cmd = 1; step();
    br_eval = 1; br_sel = 3; #1; t = br_taken;
    chk("R6 overflow test taken", {3'b0, t}, 4'b0001);
    step();
    chk("R6 ovf normal", cc_code, 4'b0000);
    upd(0, 0, 0);
    rev_cmd = 1; step();
    br_eval = 1; br_sel = 2; #1; t = br_taken;
    chk("R6 pos-or-zero taken", {3'b0, t}, 4'b0001);
    step();
    chk("R6 pos normal", cc_code, 4'b1101);
  endtask

  task automatic t_save();
    logic t;
    upd(0, 0, 0);
    save = 1; step();
    upd(1, 0, 0);
    rev_cmd = 1; step();
    chk("R9 before restore", cc_code, 4'b1000);
    restore = 1; upd_en = 1; res_ovf = 1; step();
    chk("R9 restore wins", cc_code, 4'b1101);
    rev_cmd = 1; step();
    chk("R9 restored flag normal", cc_code, 4'b0010);
    save = 1; step();
    br_eval = 1; br_sel = 0; step();
    upd(0, 1, 0);
    chk("R9 after branch", cc_code, 4'b0001);
    restore = 1; step();
    chk("R9 reversed restored", cc_code, 4'b0010);
    upd(0, 0, 1);
    chk("R9 restored flag locks", cc_code, 4'b0010);
    br_eval = 1; br_sel = 0; #1; t = br_taken;
    chk("R9 taken from reversed", {3'b0, t}, 4'b0000);
    step();
    chk("R9 unreversed", cc_code, 4'b1101);
  endtask

  task automatic t_same_cycle();
    upd(0, 1, 0);
    rev_cmd = 1; upd_en = 1; res_neg = 1; step();
    chk("R10 reverse wins", cc_code, 4'b1110);
    rev_cancel = 1; step();
    chk("R10 update dropped", cc_code, 4'b0001);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    t_reset();
    t_update();
    t_reverse();
    t_lock();
    t_branch_rev();
    t_save();
    t_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule